// File: doc/BRIEF.md
# Low-Voltage Detect Control Register

This block is an 8-bit status and control register for a supply-voltage monitor. Software uses it to enable the detector and to choose what a detected brown-out does. A detection can raise an interrupt, request a system reset, or just set a flag for polling. Software also chooses whether the detector stays alive in stop mode and whether the bandgap reference buffer is switched on.

A synchronized event line from the analog comparator sets a sticky flag, but only while detection is enabled. Software clears the flag by writing a one to a write-only acknowledge bit. The master detect enable and the reset enable can be changed only by the first bus write after reset. That write locks both bits together, and every later value written to them is dropped.

Top module: `lvd_ctrl_reg`

## Requirements
- R1: After reset the register reads 0x1C (bits 4, 3, 2 set), and the outputs are irq_req 0, rst_req 0, det_en 1 and bg_buf_en 0.
- R2: Bit 4 (reset enable) and bit 2 (master detect enable) take the value of the first write after reset. Every later write leaves them unchanged.
- R3: Bit 5 (interrupt enable), bit 3 (stop-mode enable) and bit 0 (buffer enable) take the written value on every write.
- R4: When det_en is 1 and lv_event is high at a clock edge, bit 7 (the flag) reads 1 after that edge and stays set.
- R5: While bit 2 is 0, det_en is 0 and lv_event does not set the flag.
- R6: A write with bit 6 set clears the flag, provided no detected event arrives in the same cycle. Bit 6 always reads 0.
- R7: If an acknowledge write and a detected event arrive in the same cycle, the flag stays set.
- R8: irq_req is 1 exactly when bit 5 and the flag are both 1.
- R9: rst_req is 1 exactly when bit 4, bit 2 and the flag are all 1.
- R10: While stop_mode is 1 and bit 3 is 0, det_en is 0 and lv_event is ignored. When bit 3 is 1, detection continues in stop mode.
- R11: Bit 1 always reads 0. Writing a one to bit 7 does not set the flag.
- R12: bg_buf_en follows bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Current read value of the register |
| lv_event | input | 1 | Synchronized low-voltage event from the comparator |
| stop_mode | input | 1 | High while the system is in stop mode |
| irq_req | output | 1 | Interrupt request |
| rst_req | output | 1 | System reset request |
| det_en | output | 1 | Enable for the analog detector |
| bg_buf_en | output | 1 | Enable for the bandgap reference buffer |

## Verification
The hardest case to reach from the ports is a flag clear that races a detection: an acknowledge write and a live event in the same cycle, with the write-once bits already locked at 1. The stimulus table gets there by setting the flag with an ordinary write that carries an event, then repeating it with the acknowledge bit set and the event still high. Testing the write-once behaviour in the opposite direction, where detection is disabled for good, needs a fresh reset. A directed test therefore resets the block, locks the enables at 0, and then shows that neither a later write nor an event can revive detection.

// File: rtl/lvd_pkg.sv
package lvd_pkg;
   localparam int REG_W      = 8;
   localparam int POS_FLAG   = 7;
   localparam int POS_ACK    = 6;
   localparam int POS_IRQEN  = 5;
   localparam int POS_RSTEN  = 4;
   localparam int POS_STOPEN = 3;
   localparam int POS_DETEN  = 2;
   localparam int POS_RSVD   = 1;
   localparam int POS_BGEN   = 0;

   typedef struct packed {
      logic irq_en;
      logic rst_en;
      logic stop_en;
      logic det_en;
      logic bg_en;
   } lvd_cfg_t;

   localparam lvd_cfg_t CFG_RESET = '{irq_en: 1'b0, rst_en: 1'b1, stop_en: 1'b1,
                                      det_en: 1'b1, bg_en: 1'b0};
endpackage

// File: rtl/lvd_lock_ctl.sv
module lvd_lock_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_stb,
   output logic locked
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      locked <= 1'b0;
      else if (wr_stb) locked <= 1'b1;
   end
endmodule

// File: rtl/lvd_cfg_bits.sv
module lvd_cfg_bits
   import lvd_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_stb,
   input  logic [W-1:0] wr_data,
   input  logic         locked,
   output lvd_cfg_t     cfg
);
   lvd_cfg_t cfg_d;

   always_comb begin
      cfg_d = cfg;
      if (wr_stb) begin
         cfg_d.irq_en  = wr_data[POS_IRQEN];
         cfg_d.stop_en = wr_data[POS_STOPEN];
         cfg_d.bg_en   = wr_data[POS_BGEN];
         if (!locked) begin
            cfg_d.rst_en = wr_data[POS_RSTEN];
            cfg_d.det_en = wr_data[POS_DETEN];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg <= CFG_RESET;
      else        cfg <= cfg_d;
   end
endmodule

// File: rtl/lvd_flag_trk.sv
module lvd_flag_trk (
   input  logic clk,
   input  logic rst_n,
   input  logic detect_live,
   input  logic event_in,
   input  logic ack,
   output logic flag
);
   logic set_now;
   assign set_now = detect_live & event_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag <= 1'b0;
      else if (set_now) flag <= 1'b1;
      else if (ack)     flag <= 1'b0;
   end
endmodule

// File: rtl/lvd_ctrl_reg.sv
module lvd_ctrl_reg
   import lvd_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter bit OUT_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              lv_event,
   input  logic              stop_mode,
   output logic              irq_req,
   output logic              rst_req,
   output logic              det_en,
   output logic              bg_buf_en
);
   localparam int MSB = DATA_W - 1;

   if (DATA_W != REG_W) begin : g_bad_width
      $error("lvd_ctrl_reg: DATA_W must equal %0d", REG_W);
   end

   logic     wr_locked;
   lvd_cfg_t cfg;
   logic     flag;
   logic     detect_live;
   logic     ack_wr;
   logic     irq_c;
   logic     rst_c;

   assign ack_wr      = bus_we & bus_wdata[POS_ACK];
   assign detect_live = cfg.det_en & (~stop_mode | cfg.stop_en);

   lvd_lock_ctl u_lock (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_stb (bus_we),
      .locked (wr_locked)
   );

   lvd_cfg_bits #(.W(DATA_W)) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_stb  (bus_we),
      .wr_data (bus_wdata),
      .locked  (wr_locked),
      .cfg     (cfg)
   );

   lvd_flag_trk u_flag (
      .clk         (clk),
      .rst_n       (rst_n),
      .detect_live (detect_live),
      .event_in    (lv_event),
      .ack         (ack_wr),
      .flag        (flag)
   );

   assign irq_c = cfg.irq_en & flag;
   assign rst_c = cfg.rst_en & cfg.det_en & flag;

   if (OUT_REG) begin : g_req_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            irq_req <= 1'b0;
            rst_req <= 1'b0;
         end else begin
            irq_req <= irq_c;
            rst_req <= rst_c;
         end
      end
   end else begin : g_req_comb
      assign irq_req = irq_c;
      assign rst_req = rst_c;
   end

   assign det_en    = detect_live;
   assign bg_buf_en = cfg.bg_en;

   always_comb begin
      bus_rdata             = '0;
      bus_rdata[POS_FLAG]   = flag;
      bus_rdata[POS_ACK]    = 1'b0;
      bus_rdata[POS_IRQEN]  = cfg.irq_en;
      bus_rdata[POS_RSTEN]  = cfg.rst_en;
      bus_rdata[POS_STOPEN] = cfg.stop_en;
      bus_rdata[POS_DETEN]  = cfg.det_en;
      bus_rdata[POS_RSVD]   = 1'b0;
      bus_rdata[POS_BGEN]   = cfg.bg_en;
      bus_rdata[MSB]        = flag;
   end
endmodule

// File: rtl/lvd_ctrl_reg_chk.sv
module lvd_ctrl_reg_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       bus_we,
   input logic [7:0] bus_wdata,
   input logic [7:0] bus_rdata,
   input logic       lv_event,
   input logic       stop_mode,
   input logic       irq_req,
   input logic       rst_req,
   input logic       det_en,
   input logic       wr_locked
);
   AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      wr_locked |=> ($stable(bus_rdata[4]) && $stable(bus_rdata[2]))); // R2

   AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (det_en && lv_event) |=> bus_rdata[7]); // R4

   AST_NO_DET_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (!det_en && !bus_rdata[7]) |=> !bus_rdata[7]); // R5

   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_wdata[6] && !(det_en && lv_event)) |=> !bus_rdata[7]); // R6

   AST_ACK_RACE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_wdata[6] && det_en && lv_event) |=> bus_rdata[7]); // R7

   AST_IRQ_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (bus_rdata[7] && bus_rdata[5])); // R8

   AST_RST_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> (bus_rdata[7] && bus_rdata[4] && bus_rdata[2])); // R9

   AST_STOP_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_mode && !bus_rdata[3]) |-> !det_en); // R10
endmodule

bind lvd_ctrl_reg lvd_ctrl_reg_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_we    (bus_we),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .lv_event  (lv_event),
   .stop_mode (stop_mode),
   .irq_req   (irq_req),
   .rst_req   (rst_req),
   .det_en    (det_en),
   .wr_locked (wr_locked)
);

// File: tb/lvd_ctrl_reg_bench.sv
module lvd_ctrl_reg_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_we = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       lv_event = 1'b0;
   logic       stop_mode = 1'b0;
   logic       irq_req, rst_req, det_en, bg_buf_en;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #2 clk = ~clk;

   lvd_ctrl_reg u_lvd_ctrl_reg (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_we    (bus_we),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .lv_event  (lv_event),
      .stop_mode (stop_mode),
      .irq_req   (irq_req),
      .rst_req   (rst_req),
      .det_en    (det_en),
      .bg_buf_en (bg_buf_en)
   );

   // {we, wdata[7:0], event, stop, exp_rdata[7:0], exp {irq, rst, det, bg}}
   localparam int NV = 13;
   localparam logic [22:0] VEC [NV] = '{
      {1'b1, 8'h35, 1'b0, 1'b0, 8'h35, 4'b0011},
      {1'b1, 8'h21, 1'b0, 1'b0, 8'h35, 4'b0011},
      {1'b0, 8'h00, 1'b1, 1'b0, 8'hB5, 4'b1111},
      {1'b1, 8'h75, 1'b0, 1'b0, 8'h35, 4'b0011},
      {1'b1, 8'h01, 1'b1, 1'b0, 8'h95, 4'b0111},
      {1'b1, 8'h41, 1'b1, 1'b0, 8'h95, 4'b0111},
      {1'b1, 8'h41, 1'b0, 1'b0, 8'h15, 4'b0011},
      {1'b0, 8'h00, 1'b1, 1'b1, 8'h15, 4'b0001},
      {1'b1, 8'h0B, 1'b0, 1'b1, 8'h1D, 4'b0011},
      {1'b0, 8'h00, 1'b1, 1'b1, 8'h9D, 4'b0111},
      {1'b1, 8'h48, 1'b0, 1'b0, 8'h1C, 4'b0010},
      {1'b1, 8'h88, 1'b0, 1'b0, 8'h1C, 4'b0010},
      {1'b0, 8'h00, 1'b0, 1'b0, 8'h1C, 4'b0010}
   };
   localparam string TAG [NV] = '{
      "R3 R12", "R2", "R4 R8 R9", "R6", "R8 R9", "R7", "R6",
      "R10", "R11 R10", "R10", "R6 R12", "R11", "R11"
   };

   task automatic check(input string req, input string what,
                        input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
      end
   endtask

   task automatic step(input logic we, input logic [7:0] wd,
                       input logic ev, input logic st);
      @(negedge clk);
      bus_we = we; bus_wdata = wd; lv_event = ev; stop_mode = st;
      @(posedge clk);
      #1;
   endtask

   task automatic check_all(input string req, input logic [7:0] rd, input logic [3:0] o);
      check(req, "rdata", bus_rdata, rd);
      check(req, "irq/rst/det/bg", {4'h0, irq_req, rst_req, det_en, bg_buf_en}, {4'h0, o});
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; bus_we = 1'b0; bus_wdata = '0; lv_event = 1'b0; stop_mode = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      #1;
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected<=20000 cycles", cycles);
         finish_run();
      end
   end

   initial begin
      do_reset();
      check_all("R1", 8'h1C, 4'b0010);

      for (int i = 0; i < NV; i++) begin
         step(VEC[i][22], VEC[i][21:14], VEC[i][13], VEC[i][12]);
         check_all(TAG[i], VEC[i][11:4], VEC[i][3:0]);
      end

      // Second reset: lock the enables at 0, then try to revive them
      do_reset();
      check_all("R1", 8'h1C, 4'b0010);
      step(1'b1, 8'h00, 1'b0, 1'b0);
      check_all("R2", 8'h00, 4'b0000);
      step(1'b1, 8'h14, 1'b0, 1'b0);
      check_all("R2", 8'h00, 4'b0000);
      step(1'b0, 8'h00, 1'b1, 1'b0);
      check_all("R5", 8'h00, 4'b0000);
      step(1'b0, 8'h00, 1'b0, 1'b0);
      check_all("R5", 8'h00, 4'b0000);

      finish_run();
   end
endmodule